// File: doc/BRIEF.md
# Framed Serial Result Output Shifter

This block sends one conversion result per frame on a single serial data line. A 12-bit result, a 3-bit channel address and a coding flag come in as parallel values from the rest of the converter logic. When the active-low frame strobe falls, the block captures them into a 16-bit frame: coding flag, then channel address, then result. If the flag asks for two's complement, the result is recoded on the way in. One bit is presented per falling edge of the serial clock for as long as the strobe stays low.

The serial clock and the strobe are sampled by the block's own system clock. Edges are found by comparing each input with its value one cycle earlier, so both inputs must already be synchronous to that clock. The strobe can share a wire with the strobe that frames control writes, so one frame can read and write at the same time. Once a frame is finished or cut short, the line rests at 0 and a done flag is raised.

Top module: `serout_result_tx`

## Requirements
- R1: After reset, `sdo` is 0 and `done` is 1.
- R2: The first system clock edge that sees `frame_n` low after it was high captures the frame. From that edge on, `done` is 0 and `sdo` carries frame bit 15.
- R3: Frame bits are ordered from bit 15 down to bit 0. Bit 15 is the coding flag, bits 14..12 are the channel address (most significant first) and bits 11..0 are the result (most significant first).
- R4: Each falling edge of `ser_clk` seen while a frame is active moves `sdo` on to the next lower frame bit.
- R5: With the coding flag at 0, bits 11..0 equal the result unchanged (straight binary).
- R6: With the coding flag at 1, bits 11..0 equal the result with its bit 11 inverted (two's complement).
- R7: Changes on `res_fmt`, `res_chan` or `res_data` after capture do not affect the frame being sent.
- R8: After 16 falling edges, `sdo` is 0 and `done` is 1. Further `ser_clk` edges while `frame_n` stays low change neither output.
- R9: `frame_n` going high mid-frame ends the frame: `sdo` goes to 0 and `done` to 1. The next falling strobe restarts from bit 15 with a fresh capture.
- R10: Rising edges of `ser_clk`, and any `ser_clk` activity while `frame_n` is high, leave `sdo` and `done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, already synchronous to `clk` |
| frame_n | input | 1 | Active-low frame strobe |
| res_fmt | input | 1 | Coding flag: 0 straight binary, 1 two's complement |
| res_chan | input | 3 | Channel address of the result |
| res_data | input | 12 | Conversion result in straight binary |
| sdo | output | 1 | Serial data out, 0 when no frame is active |
| done | output | 1 | High when no frame is being shifted |

## Verification
The bench builds the block with its default parameters: a 12-bit result and a 3-bit address, which makes a 16-bit frame and a 5-bit bit counter. This size lets it walk every bit position, including the full-frame terminal count and the overrun edges that follow it. It also covers the inversion of result bit 11 at both ends of the code range (0x800 and 0x7FF) and an abort after a partial frame.

// File: rtl/serout_pkg.sv
package serout_pkg;

    localparam int RES_W_DEF = 12;
    localparam int ADR_W_DEF = 3;

    typedef enum logic {
        CODE_STRAIGHT = 1'b0,
        CODE_TWOS     = 1'b1
    } code_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    // events decoded from the sampled serial inputs
    typedef struct packed {
        logic sclk_fall;
        logic strb_fall;
        logic strb_high;
    } ser_evt_t;

endpackage

// File: rtl/serout_edge.sv
module serout_edge
    import serout_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_clk,
    input  logic     frame_n,
    output ser_evt_t evt
);

    logic sclk_q;
    logic strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            strb_q <= 1'b1;
        end else begin
            sclk_q <= ser_clk;
            strb_q <= frame_n;
        end
    end

    always_comb begin
        evt.sclk_fall = sclk_q & ~ser_clk;
        evt.strb_fall = strb_q & ~frame_n;
        evt.strb_high = frame_n;
    end

endmodule

// File: rtl/serout_frame_build.sv
module serout_frame_build
    import serout_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int ADR_W   = 3,
    localparam int FRAME_W = 1 + ADR_W + RES_W
) (
    input  logic               fmt,
    input  logic [ADR_W-1:0]   adr,
    input  logic [RES_W-1:0]   res,
    output logic [FRAME_W-1:0] frame
);

    logic [RES_W-1:0] coded;

    // two's complement of an offset-binary code: flip its top bit
    always_comb begin
        coded = res;
        if (code_e'(fmt) == CODE_TWOS) begin
            coded[RES_W-1] = ~res[RES_W-1];
        end
    end

    assign frame = {fmt, adr, coded};

endmodule

// File: rtl/serout_shifter.sv
module serout_shifter
    import serout_pkg::*;
#(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  ser_evt_t           evt,
    input  logic [FRAME_W-1:0] frame,
    output logic               sdo,
    output logic               done
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    phase_e             ph;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            shreg <= '0;
            cnt   <= '0;
        end else if (evt.strb_fall) begin
            ph    <= PH_SHIFT;
            shreg <= frame;
            cnt   <= '0;
        end else if (evt.strb_high) begin
            ph    <= PH_IDLE;
        end else if (ph == PH_SHIFT && evt.sclk_fall) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            cnt   <= cnt + CNT_W'(1);
            if (cnt == LAST_IDX) begin
                ph <= PH_IDLE;
            end
        end
    end

    assign sdo  = (ph == PH_SHIFT) & shreg[FRAME_W-1];
    assign done = (ph == PH_IDLE);

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        evt.strb_fall |=> (ph == PH_SHIFT && cnt == '0));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SHIFT && evt.sclk_fall && !evt.strb_fall && !evt.strb_high)
        |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt.sclk_fall && !evt.strb_fall) |=> ($stable(shreg) && $stable(cnt)));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        evt.strb_high |=> (done && !sdo));

    // R8
    bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SHIFT) |-> (cnt < CNT_W'(FRAME_W)));

endmodule

// File: rtl/serout_result_tx.sv
module serout_result_tx
    import serout_pkg::*;
#(
    parameter int RES_W = serout_pkg::RES_W_DEF,
    parameter int ADR_W = serout_pkg::ADR_W_DEF,
    localparam int FRAME_W = 1 + ADR_W + RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             frame_n,
    input  logic             res_fmt,
    input  logic [ADR_W-1:0] res_chan,
    input  logic [RES_W-1:0] res_data,
    output logic             sdo,
    output logic             done
);

    ser_evt_t           evt;
    logic [FRAME_W-1:0] frame;

    serout_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .frame_n (frame_n),
        .evt     (evt)
    );

    serout_frame_build #(
        .RES_W (RES_W),
        .ADR_W (ADR_W)
    ) u_build (
        .fmt   (res_fmt),
        .adr   (res_chan),
        .res   (res_data),
        .frame (frame)
    );

    serout_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .frame (frame),
        .sdo   (sdo),
        .done  (done)
    );

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (done && !sdo));

endmodule

// File: tb/sim_serout_result_tx.sv
module sim_serout_result_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        frame_n = 1'b1;
    logic        res_fmt = 1'b0;
    logic [2:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic        sdo;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serout_result_tx u0 (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .frame_n  (frame_n),
        .res_fmt  (res_fmt),
        .res_chan (res_chan),
        .res_data (res_data),
        .sdo      (sdo),
        .done     (done)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one full serial clock period, ends one sample point after the falling edge is seen
    task automatic sclk_pulse();
        ser_clk = 1'b1;
        step();
        ser_clk = 1'b0;
        step();
    endtask

    function automatic logic [15:0] model(input logic f, input logic [2:0] c, input logic [11:0] d);
        logic [11:0] cd;
        cd = d;
        if (f) cd[11] = ~d[11];
        return {f, c, cd};
    endfunction

    task automatic shift_range(input string req, input logic [15:0] exp, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            chk(req, {15'b0, sdo}, {15'b0, exp[i]});
            chk(req, {15'b0, done}, 16'd0);
            sclk_pulse();
        end
    endtask

    task automatic expect_idle(input string req);
        chk(req, {15'b0, sdo}, 16'd0);
        chk(req, {15'b0, done}, 16'd1);
    endtask

    task automatic start_frame(input logic f, input logic [2:0] c, input logic [11:0] d);
        res_fmt = f; res_chan = c; res_data = d;
        frame_n = 1'b0;
        step();
    endtask

    task automatic end_frame();
        frame_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        expect_idle("R1 reset");
    endtask

    task automatic t_straight();
        start_frame(1'b0, 3'd5, 12'hA53);
        shift_range("R3 R5 straight order", 16'h5A53, 15, 0);
        expect_idle("R8 end of frame");
        end_frame();
    endtask

    task automatic t_twos_low();
        start_frame(1'b1, 3'd2, 12'h800);
        shift_range("R6 twos 0x800", model(1'b1, 3'd2, 12'h800), 15, 0);
        expect_idle("R8 end");
        end_frame();
    endtask

    task automatic t_twos_high();
        start_frame(1'b1, 3'd7, 12'h7FF);
        chk("R6 model", model(1'b1, 3'd7, 12'h7FF), 16'hFFFF);
        shift_range("R6 twos 0x7FF", 16'hFFFF, 15, 0);
        end_frame();
    endtask

    task automatic t_latch();
        logic [15:0] e;
        e = model(1'b0, 3'd3, 12'h123);
        start_frame(1'b0, 3'd3, 12'h123);
        shift_range("R7 before change", e, 15, 13);
        res_fmt = 1'b1; res_chan = 3'd4; res_data = 12'hFFF;
        step();
        shift_range("R7 after change", e, 12, 0);
        end_frame();
    endtask

    task automatic t_overrun();
        start_frame(1'b0, 3'd1, 12'h0F0);
        shift_range("R4 frame", model(1'b0, 3'd1, 12'h0F0), 15, 0);
        for (int k = 0; k < 3; k++) begin
            sclk_pulse();
            expect_idle("R8 overrun");
        end
        end_frame();
    endtask

    task automatic t_abort();
        logic [15:0] e;
        e = model(1'b1, 3'd6, 12'h5C3);
        start_frame(1'b1, 3'd6, 12'h5C3);
        shift_range("R9 partial", e, 15, 11);
        end_frame();
        expect_idle("R9 aborted");
        sclk_pulse();
        expect_idle("R10 sclk while strobe high");
        e = model(1'b0, 3'd4, 12'h3AC);
        start_frame(1'b0, 3'd4, 12'h3AC);
        shift_range("R9 restart", e, 15, 0);
        end_frame();
    endtask

    task automatic t_rise_only();
        logic [15:0] e;
        e = model(1'b0, 3'd2, 12'h9E1);
        start_frame(1'b0, 3'd2, 12'h9E1);
        chk("R2 first bit", {15'b0, sdo}, {15'b0, e[15]});
        ser_clk = 1'b1;
        step();
        step();
        chk("R10 rise no shift", {15'b0, sdo}, {15'b0, e[15]});
        chk("R10 rise done", {15'b0, done}, 16'd0);
        ser_clk = 1'b0;
        step();
        shift_range("R4 after rise", e, 14, 0);
        end_frame();
    endtask

    initial begin
        t_reset();
        t_straight();
        t_twos_low();
        t_twos_high();
        t_latch();
        t_overrun();
        t_abort();
        t_rise_only();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule